// File: doc/BRIEF.md
# Sampled PI Voltage Regulator Datapath

This block is the arithmetic core of a digital voltage loop for a switched-mode converter. Each time a sample strobe arrives it takes a target voltage code and a measured output voltage code and subtracts the measurement from the target. It then adds a proportional term (gain times the new error) to an integral term (gain times the running sum of all errors) and limits the result to a bounded command range. That command later becomes the duty word of a PWM stage whose output an RC filter smooths into an analog level. Both gains come in on ports as signed fixed-point values with eight fractional bits.

The running sum stops growing in the direction of a limit while the command sits at that limit, so the loop recovers at once when the error changes sign. A mapping input can flip the output so that a larger command gives a lower code. An inverting analog stage downstream needs this, because a larger command must still end up as a larger peak-current reference after that stage. Each strobe gives one registered result two cycles later. The pipeline accepts a strobe on every cycle.

Top module: `pi_volt_reg`

## Requirements
- R1: The error is the signed difference target minus measurement (17 bits for 16-bit codes). With a positive proportional gain and zero integral gain, a positive error gives a positive command and a negative error gives command 0.
- R2: Each update sets the integral sum to S' = S + e. The unclamped value is floor((Kp*e + Ki*S') / 256), where Kp and Ki are signed Q8.8 values and floor rounds toward minus infinity.
- R3: The command is the unclamped value limited to the range 0 to CMD_MAX, where CMD_MAX = 2^OW - 1 (4095 for OW = 12).
- R4: The integral sum keeps its old value when the unclamped value is above CMD_MAX and e > 0, or below 0 and e < 0. The sum also saturates at the signed AW-bit limits.
- R5: With inv_map = 0 the output code equals the command. With inv_map = 1 it equals CMD_MAX minus the command.
- R6: valid_out is high for exactly one cycle, two clock cycles after the cycle in which valid_in was high.
- R7: A synchronous reset clears the integral sum and drops valid_out. It drives the output to the minimum-current code: 0 when inv_map = 0, and CMD_MAX when inv_map = 1.
- R8: In cycles with no strobe, the output code and the integral sum do not change, whatever happens on the target and measurement inputs.
- R9: Strobes on consecutive cycles each give their own result, in order, on consecutive cycles. Each result uses the integral sum left by the update before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Sample strobe, one update per high cycle |
| inv_map | input | 1 | 1 selects the inverted output mapping |
| kp | input | GW (16) | Proportional gain, signed Q8.8 |
| ki | input | GW (16) | Integral gain, signed Q8.8 |
| ref_code | input | DW (16) | Target voltage code, signed |
| meas_code | input | DW (16) | Measured output voltage code, signed |
| out_code | output | OW (12) | Mapped command code for the PWM stage |
| valid_out | output | 1 | Result strobe |

## Verification
The hardest state to reach from the ports is a hidden integral sum that differs from what the output suggests. This happens after the command has been held at a limit while the error kept pushing in the same direction. The bench builds that case on purpose: it runs a series of large same-sign errors with only integral gain until the output clamps, then applies one small error of the opposite sign. The very next output shows whether the sum was frozen, because a sum that kept growing would leave the output at the limit. Near-exhaustive sweeps of errors under several gain pairs also reach both clamps from inside the range, and the bench compares every result with a running integer model.

// File: rtl/pi_pkg.sv
package pi_pkg;

  // Wide signed working type; all intermediate products fit inside it.
  typedef logic signed [63:0] wide_t;

  // Unclamped control law: (kp*e + ki*s) scaled down by the fraction bits.
  function automatic wide_t f_pi_raw(wide_t kp, wide_t ki, wide_t e,
                                     wide_t s, int frac);
    return (kp * e + ki * s) >>> frac;
  endfunction

  // Limit a value to [lo, hi].
  function automatic wide_t f_clamp(wide_t v, wide_t lo, wide_t hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // Integrator freeze decision: block growth toward an active limit.
  function automatic logic f_hold(logic above, logic below, wide_t e);
    return (above && (e > 0)) || (below && (e < 0));
  endfunction

endpackage

// File: rtl/pi_err_stage.sv
module pi_err_stage
  import pi_pkg::*;
#(
  parameter int DW = 16,
  localparam int EW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic signed [DW-1:0] ref_code,
  input  logic signed [DW-1:0] meas_code,
  output logic signed [EW-1:0] err_q,
  output logic                 v1_q
);

  logic signed [EW-1:0] err_d;

  always_comb begin
    err_d = EW'(wide_t'(ref_code) - wide_t'(meas_code));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q <= '0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= valid_in;
      if (valid_in) err_q <= err_d;
    end
  end

endmodule

// File: rtl/pi_law.sv
module pi_law
  import pi_pkg::*;
#(
  parameter int GW   = 16,
  parameter int EW   = 17,
  parameter int AW   = 32,
  parameter int OW   = 12,
  parameter int FRAC = 8
) (
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [EW-1:0] err,
  input  logic signed [AW-1:0] acc_cand,
  output logic        [OW-1:0] cmd,
  output logic                 sat_hi,
  output logic                 sat_lo,
  output logic                 acc_hold
);

  localparam wide_t CMD_MAX_W = (wide_t'(1) <<< OW) - 1;

  wide_t raw;

  always_comb begin
    raw      = f_pi_raw(wide_t'(kp), wide_t'(ki), wide_t'(err),
                        wide_t'(acc_cand), FRAC);
    sat_hi   = raw > CMD_MAX_W;
    sat_lo   = raw < 0;
    cmd      = OW'(f_clamp(raw, 0, CMD_MAX_W));
    acc_hold = f_hold(sat_hi, sat_lo, wide_t'(err));
  end

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
  import pi_pkg::*;
#(
  parameter int EW = 17,
  parameter int AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic                 hold,
  input  logic signed [EW-1:0] err,
  output logic signed [AW-1:0] acc_q,
  output logic signed [AW-1:0] acc_cand
);

  localparam wide_t A_MAX = (wide_t'(1) <<< (AW - 1)) - 1;
  localparam wide_t A_MIN = -A_MAX - 1;

  always_comb begin
    acc_cand = AW'(f_clamp(wide_t'(acc_q) + wide_t'(err), A_MIN, A_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (upd && !hold) begin
      acc_q <= acc_cand;
    end
  end

endmodule

// File: rtl/pi_out_stage.sv
module pi_out_stage #(
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic          inv_map,
  input  logic [OW-1:0] cmd,
  output logic [OW-1:0] out_code,
  output logic          valid_out
);

  localparam logic [OW-1:0] CMD_MAX = '1;

  logic [OW-1:0] mapped;

  always_comb begin
    mapped = inv_map ? (CMD_MAX - cmd) : cmd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_code  <= inv_map ? CMD_MAX : '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= upd;
      if (upd) out_code <= mapped;
    end
  end

endmodule

// File: rtl/pi_volt_reg.sv
module pi_volt_reg #(
  parameter int DW   = 16,
  parameter int GW   = 16,
  parameter int AW   = 32,
  parameter int OW   = 12,
  parameter int FRAC = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic                 inv_map,
  input  logic signed [GW-1:0] kp,
  input  logic signed [GW-1:0] ki,
  input  logic signed [DW-1:0] ref_code,
  input  logic signed [DW-1:0] meas_code,
  output logic        [OW-1:0] out_code,
  output logic                 valid_out
);

  localparam int EW = DW + 1;

  // Named internal events, visible to the bound checker.
  logic signed [EW-1:0] err_s;
  logic                 v1;
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_cand;
  logic        [OW-1:0] cmd;
  logic                 sat_hi;
  logic                 sat_lo;
  logic                 acc_hold;

  pi_err_stage #(.DW(DW)) u_err (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .ref_code  (ref_code),
    .meas_code (meas_code),
    .err_q     (err_s),
    .v1_q      (v1)
  );

  pi_integrator #(.EW(EW), .AW(AW)) u_int (
    .clk      (clk),
    .rst      (rst),
    .upd      (v1),
    .hold     (acc_hold),
    .err      (err_s),
    .acc_q    (acc_q),
    .acc_cand (acc_cand)
  );

  pi_law #(.GW(GW), .EW(EW), .AW(AW), .OW(OW), .FRAC(FRAC)) u_law (
    .kp       (kp),
    .ki       (ki),
    .err      (err_s),
    .acc_cand (acc_cand),
    .cmd      (cmd),
    .sat_hi   (sat_hi),
    .sat_lo   (sat_lo),
    .acc_hold (acc_hold)
  );

  pi_out_stage #(.OW(OW)) u_out (
    .clk       (clk),
    .rst       (rst),
    .upd       (v1),
    .inv_map   (inv_map),
    .cmd       (cmd),
    .out_code  (out_code),
    .valid_out (valid_out)
  );

endmodule

// File: rtl/pi_volt_reg_checker.sv
module pi_volt_reg_checker #(
  parameter int AW = 32,
  parameter int OW = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 valid_in,
  input logic                 inv_map,
  input logic                 v1,
  input logic                 sat_hi,
  input logic                 sat_lo,
  input logic                 acc_hold,
  input logic signed [AW-1:0] acc_q,
  input logic        [OW-1:0] out_code,
  input logic                 valid_out
);

  localparam logic [OW-1:0] CMD_MAX = '1;

  p_valid_lat_r6: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $past(valid_in, 2));

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    $past(valid_in, 2) |-> valid_out);

  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (v1 && sat_hi && !inv_map) |=> (out_code == CMD_MAX));

  p_clamp_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (v1 && sat_lo && !inv_map) |=> (out_code == '0));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (v1 && acc_hold) |=> $stable(acc_q));

  p_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> ($stable(acc_q) && $stable(out_code)));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> ((acc_q == '0) && !valid_out));

endmodule

bind pi_volt_reg pi_volt_reg_checker #(.AW(AW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_in  (valid_in),
  .inv_map   (inv_map),
  .v1        (v1),
  .sat_hi    (sat_hi),
  .sat_lo    (sat_lo),
  .acc_hold  (acc_hold),
  .acc_q     (acc_q),
  .out_code  (out_code),
  .valid_out (valid_out)
);

// File: tb/pi_volt_reg_bench.sv
`timescale 1ns/1ps
module pi_volt_reg_bench;

  localparam longint TOP = 4095;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               valid_in = 1'b0;
  logic               inv_map = 1'b0;
  logic signed [15:0] kp = '0;
  logic signed [15:0] ki = '0;
  logic signed [15:0] ref_code = '0;
  logic signed [15:0] meas_code = '0;
  logic [11:0]        out_code;
  logic               valid_out;

  int     n_chk  = 0;
  int     n_fail = 0;
  longint m_sum  = 0;

  pi_volt_reg u_pi_volt_reg (
    .clk (clk), .rst (rst), .valid_in (valid_in), .inv_map (inv_map),
    .kp (kp), .ki (ki), .ref_code (ref_code), .meas_code (meas_code),
    .out_code (out_code), .valid_out (valid_out)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Floor division by 256 written with a remainder correction.
  function automatic longint div_floor256(longint t);
    longint r = t % 256;
    if (r < 0) r += 256;
    return (t - r) / 256;
  endfunction

  // Behavioural model of one update; returns the clamped command.
  function automatic longint model(longint e);
    longint cand, raw, cmd;
    cand = m_sum + e;
    if (cand > 64'sd2147483647)  cand = 64'sd2147483647;
    if (cand < -64'sd2147483648) cand = -64'sd2147483648;
    raw = div_floor256(longint'(kp) * e + longint'(ki) * cand);
    cmd = (raw > TOP) ? TOP : ((raw < 0) ? 0 : raw);
    if (!((raw > TOP && e > 0) || (raw < 0 && e < 0))) m_sum = cand;
    return cmd;
  endfunction

  function automatic longint mapped(longint cmd);
    return inv_map ? (TOP - cmd) : cmd;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; valid_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sum = 0;
    check("R7 reset output", out_code, inv_map ? TOP : 0);
    check("R7 reset valid_out", valid_out, 0);
  endtask

  // One strobe; returns with the result visible (two cycles later).
  task automatic step(int rv, int mv, string tag, output longint got);
    longint exp;
    @(negedge clk);
    ref_code = 16'(rv); meas_code = 16'(mv); valid_in = 1'b1;
    exp = mapped(model(longint'(rv) - longint'(mv)));
    @(negedge clk);
    valid_in = 1'b0;
    check("R6 no early valid_out", valid_out, 0);
    @(negedge clk);
    check("R6 valid_out two cycles later", valid_out, 1);
    check(tag, out_code, exp);
    got = out_code;
  endtask

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    longint got, held;
    longint e1, e2, e3;

    // R7: reset values for both mappings
    inv_map = 1'b0;
    do_reset();
    inv_map = 1'b1;
    do_reset();
    inv_map = 1'b0;
    do_reset();

    // R1: sign of the error
    kp = 16'sd256; ki = 16'sd0;
    step(1000, 900, "R1 positive error", got);
    check("R1 positive error raises command", got, 100);
    step(1000, 1100, "R1 negative error", got);
    check("R1 negative error lowers command", got, 0);

    // R2/R3: sweeps of errors under several gain pairs
    for (int g = 0; g < 4; g++) begin
      case (g)
        0: begin kp = 16'sd256; ki = 16'sd0;   end
        1: begin kp = 16'sd0;   ki = 16'sd64;  end
        2: begin kp = 16'sd384; ki = 16'sd32;  end
        default: begin kp = 16'sd128; ki = 16'sd300; end
      endcase
      do_reset();
      for (int i = 0; i < 129; i++) begin
        int e = ((i * 53) % 129) - 64;
        step(2000 + i * 7, 2000 + i * 7 - e * 40, "R2 sweep law", got);
      end
    end

    // R3/R4: upper clamp and freeze
    kp = 16'sd0; ki = 16'sd256;
    do_reset();
    for (int i = 0; i < 5; i++) step(3000, 2000, "R3 ramp to upper limit", got);
    check("R3 upper clamp", got, TOP);
    step(2000, 2100, "R4 recover from upper limit", got);
    check("R4 frozen sum gives immediate recovery", got, 3900);

    // R3/R4: lower clamp and freeze
    do_reset();
    step(1000, 1500, "R3 lower clamp", got);
    check("R3 lower clamp value", got, 0);
    step(1010, 1000, "R4 recover from lower limit", got);
    check("R4 frozen sum at lower limit", got, 10);

    // R5: inverted mapping
    inv_map = 1'b1;
    do_reset();
    kp = 16'sd256; ki = 16'sd0;
    step(500, 200, "R5 inverted mapping", got);
    check("R5 inverted value", got, TOP - 300);
    kp = 16'sd200; ki = 16'sd20;
    for (int i = 0; i < 40; i++) begin
      int e = (i * 29 % 81) - 40;
      step(100, 100 - e * 5, "R5 inverted sweep", got);
    end
    inv_map = 1'b0;

    // R8: idle cycles leave output and sum untouched
    kp = 16'sd0; ki = 16'sd256;
    do_reset();
    step(1500, 500, "R8 preload", held);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ref_code = 16'(i * 300); meas_code = 16'(-i * 100);
      check("R8 output held while idle", out_code, held);
      check("R8 no valid_out while idle", valid_out, 0);
    end
    step(700, 700, "R8 sum kept across idle", got);
    check("R8 zero error repeats held sum", got, 1000);

    // R9: back-to-back strobes
    kp = 16'sd128; ki = 16'sd64;
    do_reset();
    e1 = 100; e2 = 250; e3 = -80;
    @(negedge clk);
    ref_code = 16'(1000 + e1); meas_code = 16'sd1000; valid_in = 1'b1;
    e1 = model(e1);
    @(negedge clk);
    ref_code = 16'(1000 + e2); meas_code = 16'sd1000;
    e2 = model(e2);
    @(negedge clk);
    check("R9 first result", out_code, e1);
    check("R9 first valid", valid_out, 1);
    ref_code = 16'(1000 + e3); meas_code = 16'sd1000;
    e3 = model(e3);
    @(negedge clk);
    valid_in = 1'b0;
    check("R9 second result", out_code, e2);
    check("R9 second valid", valid_out, 1);
    @(negedge clk);
    check("R9 third result", out_code, e3);
    check("R9 third valid", valid_out, 1);
    @(negedge clk);
    check("R6 single-cycle valid_out", valid_out, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule